// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block holds the 32-bit Count and Compare registers of a processor's system-control coprocessor. Count steps up by one on every tick-enable pulse. The pulse comes from a divider that gives a 100 MHz timer rate, so the block runs entirely on one system clock. A halt bit can freeze Count. While frozen, Count keeps its value, and counting picks up again from that value once the halt bit is cleared. Software may also load Count with a new value at any time.

When a tick moves Count onto the value held in Compare, a pending flag is set. That flag drives the timer interrupt output and stays set until software writes Compare or the block is reset. Routing the interrupt to a particular interrupt line is left to the surrounding coprocessor.

Top module: `systmr_core`

## Requirements
- R1: After reset, count_o is 0, the Compare register is 0 and irq_o is 0.
- R2: A cycle with tick_i high, with the halt bit clear and with no Count write, raises count_o by one from the next cycle on. In a cycle with tick_i low, count_o holds.
- R3: While the halt bit is 1, tick_i has no effect and count_o holds. A write to the halt bit (halt_we_i, value halt_wdata_i) takes effect from the cycle after the write.
- R4: After the halt bit is cleared, counting resumes from the held value.
- R5: cnt_we_i loads cnt_wdata_i into Count, visible on the next cycle. The load also works while halted. It wins over a tick in the same cycle, so that tick is lost.
- R6: Count wraps from 0xFFFFFFFF to 0 on a tick.
- R7: irq_o rises in the cycle after a tick steps Count to a value equal to Compare, and this includes a step that wraps.
- R8: The pending flag does not set when Count becomes equal to Compare through a Count load or through a Compare write.
- R9: cmp_we_i stores cmp_wdata_i into Compare and clears irq_o from the next cycle on. If a set would happen in the same cycle, the clear wins.
- R10: Once set, irq_o stays high across further ticks until a Compare write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer-rate enable, one pulse per tick |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 32 | Count write value |
| halt_we_i | input | 1 | Halt bit write strobe |
| halt_wdata_i | input | 1 | Halt bit write value (1 freezes Count) |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write value |
| count_o | output | 32 | Current Count value |
| irq_o | output | 1 | Timer interrupt pending |

## Verification
Every result is registered, so a write, a tick or a match shows up on count_o or irq_o exactly one clock after the edge that samples it. A halt write affects only the ticks from the following cycle on. The bench drives each stimulus 1 ns after a rising edge, waits for the next rising edge, and samples 1 ns later. The expected value therefore always sits one edge after the stimulus. Collision cases place the competing strobes in the same cycle and check the one outcome that edge produces.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  localparam int unsigned DEF_CNT_W = 32;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_STEP = 2'd1,
    UPD_LOAD = 2'd2
  } cnt_upd_e;
endpackage

// File: rtl/systmr_counter.sv
module systmr_counter
  import systmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             halt_we_i,
  input  logic             halt_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q, count_d;
  logic             halt_q;
  cnt_upd_e         upd;

  // load beats tick
  always_comb begin
    if (load_i)                upd = UPD_LOAD;
    else if (tick_i && !halt_q) upd = UPD_STEP;
    else                       upd = UPD_HOLD;
    case (upd)
      UPD_LOAD: count_d = load_val_i;
      UPD_STEP: count_d = count_q + ONE;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      if (halt_we_i) halt_q <= halt_val_i;
    end
  end

  assign count_o     = count_q;
  assign count_nxt_o = count_d;
  assign step_o      = (upd == UPD_STEP);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !halt_q && !load_i |=> count_q == $past(count_q) + ONE);
  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !load_i |=> $stable(count_q));
  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(load_val_i));
endmodule

// File: rtl/systmr_match.sv
module systmr_match
  import systmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] count_nxt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             pend_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             pend_q, hit;

  // only a counting step can expire
  assign hit = step_i && (count_nxt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_we_i) begin
        cmp_q  <= cmp_wdata_i;
        pend_q <= 1'b0;
      end else if (hit) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;

  a_r9_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> !pend_q);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !cmp_we_i |=> pend_q);
  a_r8_step_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q && !step_i |=> !pend_q);
  a_r7_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && count_nxt_i == cmp_q && !cmp_we_i |=> pend_q);
endmodule

// File: rtl/systmr_core.sv
module systmr_core
  import systmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             halt_we_i,
  input  logic             halt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_nxt;
  logic             step;

  systmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .load_i      (cnt_we_i),
    .load_val_i  (cnt_wdata_i),
    .halt_we_i   (halt_we_i),
    .halt_val_i  (halt_wdata_i),
    .count_o     (count_o),
    .count_nxt_o (count_nxt),
    .step_o      (step)
  );

  systmr_match #(.CNT_W(CNT_W)) i_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .count_nxt_i (count_nxt),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .pend_o      (irq_o)
  );

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && count_o == '1 |=> count_o == '0);
endmodule

// File: tb/test_systmr_core.sv
module test_systmr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cnt_we = 1'b0, halt_we = 1'b0, halt_wd = 1'b0, cmp_we = 1'b0;
  logic [31:0] cnt_wd = '0, cmp_wd = '0;
  logic [31:0] count;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  systmr_core i_systmr_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .halt_we_i(halt_we), .halt_wdata_i(halt_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .count_o(count), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one edge, then clear strobes 1 ns after it
  task automatic cyc();
    @(posedge clk); #1;
    cnt_we = 0; halt_we = 0; cmp_we = 0; tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 5; i++) begin tick = 1; cyc(); end
    chk("R2 five ticks", count, 32'd5);
    cyc(); cyc();
    chk("R2 no tick holds", count, 32'd5);
  endtask

  task automatic t_halt();
    halt_we = 1; halt_wd = 1; tick = 1; cyc();
    chk("R3 halt write lags one cycle", count, 32'd6);
    for (int i = 0; i < 3; i++) begin tick = 1; cyc(); end
    chk("R3 frozen", count, 32'd6);
    halt_we = 1; halt_wd = 0; tick = 1; cyc();
    chk("R3 clear lags one cycle", count, 32'd6);
    tick = 1; cyc();
    chk("R4 resume from held", count, 32'd7);
  endtask

  task automatic t_load();
    cnt_we = 1; cnt_wd = 32'd100; tick = 1; cyc();
    chk("R5 load beats tick", count, 32'd100);
    halt_we = 1; halt_wd = 1; cyc();
    cnt_we = 1; cnt_wd = 32'h55; cyc();
    chk("R5 load while halted", count, 32'h55);
    tick = 1; cyc();
    chk("R5 halted after load", count, 32'h55);
    halt_we = 1; halt_wd = 0; cyc();
  endtask

  task automatic t_match();
    cmp_we = 1; cmp_wd = 32'h60; cnt_we = 1; cnt_wd = 32'h5E; cyc();
    tick = 1; cyc();
    chk("R7 no early irq", {31'd0, irq}, 32'd0);
    tick = 1; cyc();
    chk("R7 count at compare", count, 32'h60);
    chk("R7 irq set", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 4; i++) begin tick = 1; cyc(); end
    chk("R10 irq held", {31'd0, irq}, 32'd1);
    cmp_we = 1; cmp_wd = 32'h200; cyc();
    chk("R9 compare write clears", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_no_set();
    cnt_we = 1; cnt_wd = 32'h200; cyc(); cyc();
    chk("R8 load equal no irq", {31'd0, irq}, 32'd0);
    cmp_we = 1; cmp_wd = 32'h200; cyc(); cyc();
    chk("R8 compare equal no irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_collide();
    cmp_we = 1; cmp_wd = 32'h300; cnt_we = 1; cnt_wd = 32'h2FF; cyc();
    tick = 1; cmp_we = 1; cmp_wd = 32'h400; cyc();
    chk("R9 clear wins count", count, 32'h300);
    chk("R9 clear wins irq", {31'd0, irq}, 32'd0);
    cnt_we = 1; cnt_wd = 32'h3FF; cyc();
    tick = 1; cyc();
    chk("R9 new compare stored", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_wrap();
    cmp_we = 1; cmp_wd = 32'h0; cnt_we = 1; cnt_wd = 32'hFFFF_FFFF; cyc();
    chk("R9 irq cleared before wrap", {31'd0, irq}, 32'd0);
    tick = 1; cyc();
    chk("R6 wrap to zero", count, 32'd0);
    chk("R7 irq on wrap", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_rereset();
    rst_n = 0; #5;
    chk("R10 reset clears irq", {31'd0, irq}, 32'd0);
    chk("R1 reset clears count", count, 32'd0);
    @(posedge clk); #1; rst_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_count();
    t_halt();
    t_load();
    t_match();
    t_no_set();
    t_collide();
    t_wrap();
    t_rereset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule